// File: doc/BRIEF.md
# Booth Compressor-Tree Multiply-Accumulate Array

This block is purely combinational. It takes a signed multiplicand, a signed multiplier and a wide accumulate operand, all driven from registers outside it. It returns the value `A*B + C` in redundant form: two full-width vectors whose sum modulo 2^(2N) is the result. The carry-propagate addition that merges the two vectors belongs to the stage that follows, so this array sits between an operand register bank and a final adder.

The multiplier is recoded into radix-4 signed digits, so there are only N/2 partial-product rows. Each row is a selected multiple of the multiplicand, with its sign handled by one folded constant instead of replicated sign bits. The rows, one correction word and the accumulate operand are padded to a power of two and reduced by a tree of 4:2 compressor slices. The accumulate operand takes one of the otherwise empty tree inputs, so it is added without any dedicated adder stage.

Top module: `booth_mac_array`

## Requirements
- R1: For any signed N-bit `a_i`, `b_i` and any 2N-bit `c_i`, `sum_o + carry_o` equals `a_i*b_i + c_i` taken modulo 2^(2N). The outputs follow the inputs with no clock.
- R2: The multiplier is split into N/2 overlapping triples {b[2i+1], b[2i], b[2i-1]}, with b[-1] = 0. A triple maps to the digit -2*b[2i+1] + b[2i] + b[2i-1] in {-2..2}, and row i carries that digit times `a_i`, weighted 4^i. Every triple value 000..111 gives the correct product.
- R3: Each 4:2 compressor cell takes four bits of one column plus a carry-in from the column below. The carry-in plus the four bits equal sum + 2*(carry + carry-out). The carry-out is a function of the first three inputs only, so the chain does not ripple. All-ones operands, which load every column, give the correct product.
- R4: The tree has log2(P)-1 levels, where P is the operand count rounded up to a power of two. With N = 32 that is 18 operands padded to 32, and 4 levels. Each level halves the vector count and keeps the modulo-2^(2N) total of its vectors.
- R5: `c_i` enters as one tree operand. With `a_i` or `b_i` zero, the outputs total exactly `c_i`.
- R6: Extreme operands give exact results. Most-negative times most-negative gives 2^(2N-2). Most-negative times most-positive, and most-positive squared, also give their exact values.
- R7: When `a_i*b_i + c_i` leaves the 2N-bit range, the outputs total the value wrapped modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N (32) | Signed multiplicand |
| b_i | input | N (32) | Signed multiplier, Booth-recoded |
| c_i | input | 2N (64) | Accumulate operand |
| sum_o | output | 2N (64) | Redundant result, sum vector |
| carry_o | output | 2N (64) | Redundant result, carry vector |

## Verification
The block has no state, so a wrong row, a wrong correction constant or a broken compressor column shows at once. It appears as an output total that differs from the signed reference in the same cycle the operands are applied. An error in the sign handling appears only for negative digits or negative multiplicands. A missing column carry appears only when many ones pile up in one column. The directed vectors therefore target every triple pattern, all-ones operands and the extreme operands, while random vectors cover the remaining mixes.

// File: rtl/bmac_pkg.sv
package bmac_pkg;

    // One recoded radix-4 digit: magnitude select plus sign
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdigit_t;

    // Folded sign-correction constant: each row contributes -2^(n+2i)
    function automatic logic [127:0] corr_word(int n, int rows);
        logic [127:0] k;
        k = '0;
        for (int i = 0; i < rows; i++) begin
            k = k - (128'(1) << (n + 2 * i));
        end
        return k;
    endfunction

    // Start index of tree level l in a flat node array for ops leaf vectors
    function automatic int lvl_off(int ops, int l);
        return 2 * ops - 2 * (ops >> l);
    endfunction

endpackage

// File: rtl/bmac_booth_digit.sv
module bmac_booth_digit
    import bmac_pkg::*;
(
    input  logic [2:0] trip_i,
    output bdigit_t    dig_o
);
    always_comb begin
        dig_o.neg = trip_i[2];
        dig_o.one = trip_i[1] ^ trip_i[0];
        dig_o.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                    (~trip_i[2] & trip_i[1] & trip_i[0]);
    end

    always_comb begin
        AST_DIGIT_ONEHOT: assert ($onehot0({dig_o.one, dig_o.two})); // R2
    end
endmodule

// File: rtl/bmac_pp_row.sv
module bmac_pp_row
    import bmac_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  bdigit_t      dig_i,
    output logic [N:0]   row_o,
    output logic         neg_o
);
    logic [N:0] mult;
    logic [N:0] flip;

    always_comb begin
        if (dig_i.two)      mult = {a_i, 1'b0};
        else if (dig_i.one) mult = {a_i[N-1], a_i};
        else                mult = '0;
        flip  = mult ^ {(N+1){dig_i.neg}};
        // inverted top bit; the matching -2^N lives in the correction word
        row_o = {~flip[N], flip[N-1:0]};
        neg_o = dig_i.neg;
    end

    // row value (signed, correction restored) equals digit times multiplicand
    logic [N+2:0] chk_row, chk_mag, chk_want;
    always_comb begin
        chk_row = {{3{~row_o[N]}}, row_o[N-1:0]} + {{(N+2){1'b0}}, neg_o};
        if (dig_i.two)      chk_mag = {{2{a_i[N-1]}}, a_i, 1'b0};
        else if (dig_i.one) chk_mag = {{3{a_i[N-1]}}, a_i};
        else                chk_mag = '0;
        chk_want = dig_i.neg ? (~chk_mag + 1'b1) : chk_mag;
        AST_ROW_VALUE: assert (chk_row == chk_want); // R2
    end
endmodule

// File: rtl/bmac_cmp42_cell.sv
module bmac_cmp42_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    input  logic d_i,
    input  logic cin_i,
    output logic s_o,
    output logic cy_o,
    output logic cout_o
);
    logic s1;

    always_comb begin
        // first full adder: cout depends on a,b,c only
        s1     = a_i ^ b_i ^ c_i;
        cout_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        // second full adder folds d and the neighbour's carry
        s_o    = s1 ^ d_i ^ cin_i;
        cy_o   = (s1 & d_i) | (s1 & cin_i) | (d_i & cin_i);
    end

    logic [2:0] in_w, out_w;
    always_comb begin
        in_w  = 3'(a_i) + 3'(b_i) + 3'(c_i) + 3'(d_i) + 3'(cin_i);
        out_w = 3'(s_o) + {1'b0, cy_o, 1'b0} + {1'b0, cout_o, 1'b0};
        AST_CELL_WEIGHT: assert (in_w == out_w); // R3
    end
endmodule

// File: rtl/bmac_cmp42_slice.sv
module bmac_cmp42_slice #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);
    logic [W:0]   chain;
    logic [W-1:0] cy_v;
    logic [1:0]   unused_top;

    assign chain[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_col
        bmac_cmp42_cell u_cell (
            .a_i   (a_i[j]),
            .b_i   (b_i[j]),
            .c_i   (c_i[j]),
            .d_i   (d_i[j]),
            .cin_i (chain[j]),
            .s_o   (s_o[j]),
            .cy_o  (cy_v[j]),
            .cout_o(chain[j+1])
        );
    end

    // weight 2^W falls off: arithmetic is modulo 2^W
    assign c_o        = {cy_v[W-2:0], 1'b0};
    assign unused_top = {chain[W], cy_v[W-1]};

    always_comb begin
        AST_SLICE_TOTAL: assert (W'(s_o + c_o) == W'(a_i + b_i + c_i + d_i)); // R3
    end
endmodule

// File: rtl/booth_mac_array.sv
module booth_mac_array
    import bmac_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    input  logic [2*N-1:0] c_i,
    output logic [2*N-1:0] sum_o,
    output logic [2*N-1:0] carry_o
);
    localparam int W      = 2 * N;
    localparam int ROWS   = N / 2;
    localparam int OPS    = ROWS + 2;              // rows + correction + accumulate
    localparam int PADOPS = 1 << $clog2(OPS);
    localparam int LEVELS = $clog2(PADOPS) - 1;
    localparam int NODES  = 2 * PADOPS - 2;
    localparam logic [W-1:0] CORR_K = W'(corr_word(N, ROWS));

    logic [N:0]     b_ext;
    bdigit_t        digs [ROWS];
    logic [N:0]     rows [ROWS];
    logic [ROWS-1:0] negs;
    logic [W-1:0]   corr;
    logic [W-1:0]   node [NODES];

    assign b_ext = {b_i, 1'b0};

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        bmac_booth_digit u_dig (
            .trip_i(b_ext[2*i+2:2*i]),
            .dig_o (digs[i])
        );
        bmac_pp_row #(.N(N)) u_pp (
            .a_i  (a_i),
            .dig_i(digs[i]),
            .row_o(rows[i]),
            .neg_o(negs[i])
        );
        assign node[i] = W'(rows[i]) << (2 * i);
    end

    // negate bits sit below bit N, where the constant is all zero
    always_comb begin
        corr = CORR_K;
        for (int i = 0; i < ROWS; i++) begin
            corr[2*i] = corr[2*i] | negs[i];
        end
    end

    assign node[ROWS]     = corr;
    assign node[ROWS + 1] = c_i;   // accumulate takes a free tree input
    for (genvar p = OPS; p < PADOPS; p++) begin : g_pad
        assign node[p] = '0;
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_OFF  = lvl_off(PADOPS, l);
        localparam int OUT_OFF = lvl_off(PADOPS, l + 1);
        localparam int GROUPS  = (PADOPS >> l) / 4;
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            bmac_cmp42_slice #(.W(W)) u_slice (
                .a_i(node[IN_OFF + 4*g]),
                .b_i(node[IN_OFF + 4*g + 1]),
                .c_i(node[IN_OFF + 4*g + 2]),
                .d_i(node[IN_OFF + 4*g + 3]),
                .s_o(node[OUT_OFF + 2*g]),
                .c_o(node[OUT_OFF + 2*g + 1])
            );
        end

        logic [W-1:0] tot_in, tot_out;
        always_comb begin
            tot_in  = '0;
            tot_out = '0;
            for (int k = 0; k < 4 * GROUPS; k++)  tot_in  = tot_in + node[IN_OFF + k];
            for (int k = 0; k < 2 * GROUPS; k++)  tot_out = tot_out + node[OUT_OFF + k];
            AST_LEVEL_TOTAL: assert (tot_in == tot_out); // R4
        end
    end

    assign sum_o   = node[lvl_off(PADOPS, LEVELS)];
    assign carry_o = node[lvl_off(PADOPS, LEVELS) + 1];

    logic [W-1:0] chk_ref;
    always_comb begin
        chk_ref = W'($signed({{N{a_i[N-1]}}, a_i}) * $signed({{N{b_i[N-1]}}, b_i})) + c_i;
        AST_MAC_TOTAL: assert (W'(sum_o + carry_o) == chk_ref); // R1
    end
endmodule

// File: tb/sim_booth_mac_array.sv
module sim_booth_mac_array;
    localparam int N = 32;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [W-1:0] c = '0;
    logic [W-1:0] s, cy;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    booth_mac_array #(.N(N)) u0 (
        .a_i(a), .b_i(b), .c_i(c), .sum_o(s), .carry_o(cy)
    );

    // behavioural reference: signed 64-bit arithmetic, wraps naturally
    function automatic logic [W-1:0] model(logic [N-1:0] x, logic [N-1:0] y, logic [W-1:0] z);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return W'(sx * sy) + z;
    endfunction

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                         input logic [W-1:0] z, input string tag);
        logic [W-1:0] got, exp;
        @(posedge clk);
        #1;
        a = x; b = y; c = z;
        @(negedge clk);
        got = s + cy;
        exp = model(x, y, z);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s a=%h b=%h c=%h actual=%h expected=%h", tag, x, y, z, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: operands held at zero give a zero total (R1)
        apply('0, '0, '0, "R1 reset");
        // extremes (R6)
        apply(32'h8000_0000, 32'h8000_0000, '0, "R6 min*min");
        apply(32'h8000_0000, 32'h7fff_ffff, '0, "R6 min*max");
        apply(32'h7fff_ffff, 32'h7fff_ffff, '0, "R6 max*max");
        apply(32'h7fff_ffff, 32'h8000_0000, 64'h1234, "R6 max*min+c");
        // accumulate alone (R5)
        apply('0, 32'h1357_9bdf, 64'hfedc_ba98_7654_3210, "R5 a zero");
        apply(32'hdead_beef, '0, 64'h8000_0000_0000_0001, "R5 b zero");
        // every triple pattern (R2)
        apply(32'h1234_5678, 32'haaaa_aaaa, '0, "R2 alt10");
        apply(32'h9876_5431, 32'h5555_5555, 64'h77, "R2 alt01");
        apply(32'hcafe_f00d, 32'hffff_ffff, '0, "R2 ones");
        apply(32'h0f0f_0f0f, 32'hc3c3_c3c3, '0, "R2 mixed");
        apply(32'hffff_fffe, 32'h8000_0000, 64'h5, "R2 top digit");
        for (int t = 0; t < 8; t++) begin
            apply(32'hb5a3_c7e1, {8{t[3:0]}} & 32'h7777_7777 | {8{t[0]}} << 3, '0, "R2 triples");
        end
        // column loading (R3)
        apply('1, '1, '1, "R3 all ones");
        apply(32'h8000_0001, '1, '1, "R3 heavy columns");
        // wraparound (R7)
        apply(32'h7fff_ffff, 32'h7fff_ffff, 64'hffff_ffff_ffff_ffff, "R7 wrap high");
        apply(32'h8000_0000, 32'h7fff_ffff, 64'h8000_0000_0000_0000, "R7 wrap low");
        // random mixes through every level (R1, R4)
        for (int t = 0; t < 3000; t++) begin
            apply($urandom, $urandom, {$urandom, $urandom}, "R4 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule